// File: doc/BRIEF.md
# Branch Record History Buffer

This block keeps a short history of the control transfers a core retires. Each transfer arrives with a source address, a target address, a 4-bit kind code, the privilege mode, a mispredict flag and a cycle-count field that is already encoded. The transfer is checked against privilege enables and per-kind inhibit bits. If it passes, it becomes the newest record in a circular store. The store size is chosen at run time from 16, 32, 64, 128 or 256 entries, up to the largest size the instance builds.

Software reaches three registers through a small register port: control, depth and status. It reads one record at a time through an index port, where index 0 is the newest record. Two events stop or empty the history. A counter-overflow event can freeze recording, and a clear command empties the history. An optional stack mode pushes a record for each call and drops the newest record for each return, so the history tracks the live call chain.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset, the control, depth and status registers read 0, which selects 16 records. Every index reads as an empty record.
- R2: An accepted transfer becomes index 0 and every older record moves up one index. Source word: valid flag at bit AW, address below it. Target word: mispredict flag at bit AW, address below it. Data word: kind code at bits [3:0], cycle field above it.
- R3: A transfer with mode 0 (user) is kept only when control bit 0 is set. A transfer with mode 1 (supervisor) is kept only when control bit 1 is set. Modes 2 and 3 are never kept, so a control value of 0 stops all recording.
- R4: Control bit 16+k inhibits kind k for k in {1,2,3,5,8..15}. Kinds 0, 4, 6 and 7 have no inhibit bit and are never kept.
- R5: Depth register bits [2:0] hold a field n, and the history holds 16<<n records. A write above the built maximum stores that maximum. Any depth write empties the history. Once the history is full, the oldest record drops out. An index of 16<<n or higher reads all zeros.
- R6: When control bit 2 is set, an overflow event sets status bit 0 from the next cycle on. While that bit is set, nothing is recorded. A transfer in the same cycle as the event is still kept. The bit stays set until software writes status bit 0 as 0.
- R7: A clear command empties the history and zeroes the status register. Control and depth keep their values.
- R8: With control bit 3 set (stack mode), kinds 8 and 9 push a record and kind 13 removes index 0, so older records move down one index. All other kinds are not kept. A return on an empty history changes nothing.
- R9: Control bits with no function read back 0: bits 4..15, bit 16+k for k in {0,4,6,7}, and bit 3 when stack mode is not built.
- R10: A record that was never written, has been removed or was cleared reads all three words as 0.
- R11: csr_rdata shows the register chosen by csr_sel in the same cycle: 0 control, 1 depth, 2 status, 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | A retired transfer is present this cycle |
| rec_type | input | 4 | Transfer kind code |
| rec_priv | input | 2 | Privilege mode: 0 user, 1 supervisor |
| rec_src | input | AW | Source address |
| rec_tgt | input | AW | Target address |
| rec_misp | input | 1 | Transfer was mispredicted |
| rec_cyc | input | CW | Encoded cycle-count field |
| ovf_evt | input | 1 | Local counter overflow event |
| clr_cmd | input | 1 | Empty the history and zero status |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| rd_idx | input | IW | Logical record index, 0 is the newest |
| rd_src | output | AW+1 | Source word of the indexed record |
| rd_tgt | output | AW+1 | Target word of the indexed record |
| rd_data | output | CW+4 | Data word of the indexed record |

## Verification
The assertions assume a few things about the inputs. After reset every input holds a known value. At most one transfer arrives per cycle. Pushes and pops are judged against the control and privilege values sampled at the same clock edge. The stimulus changes inputs only at the falling edge and holds them for one full cycle. It uses only privilege codes and register selects that the requirements define, and it reads records only after the edge that stored them.

// File: rtl/brh_pkg.sv
`timescale 1ns/1ps
package brh_pkg;
  localparam int TYPE_W = 4;

  typedef enum logic [TYPE_W-1:0] {
    K_NONE = 4'd0, K_EXC = 4'd1, K_IRQ = 4'd2, K_TRET = 4'd3,
    K_NTBR = 4'd4, K_TKBR = 4'd5, K_RSV6 = 4'd6, K_RSV7 = 4'd7,
    K_ICALL = 4'd8, K_DCALL = 4'd9, K_IJMP = 4'd10, K_DJMP = 4'd11,
    K_SWAP = 4'd12, K_RET = 4'd13, K_OIJMP = 4'd14, K_ODJMP = 4'd15
  } xfer_kind_e;

  // kinds that own an inhibit bit (and can therefore be recorded)
  localparam logic [15:0] INH_IMPL = 16'hFF2E;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_DEPTH = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;

  localparam int CB_UEN  = 0;
  localparam int CB_SEN  = 1;
  localparam int CB_FRZ  = 2;
  localparam int CB_STK  = 3;
  localparam int INH_LSB = 16;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
endpackage

// File: rtl/brh_regs.sv
`timescale 1ns/1ps
module brh_regs
  import brh_pkg::*;
#(
  parameter int MAX_SEL   = 2,
  parameter bit HAS_STACK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [1:0]  csr_sel,
  input  logic [31:0] csr_wdata,
  input  logic        clr_cmd,
  input  logic        ovf_evt,
  output logic [31:0] ctrl_q,
  output logic [2:0]  dsel_q,
  output logic        frozen_q,
  output logic        inval_all,
  output logic [31:0] csr_rdata
);
  localparam logic [31:0] CTRL_MASK = {INH_IMPL, 12'h000, HAS_STACK, 3'b111};
  localparam logic [2:0]  SEL_LIMIT = 3'(MAX_SEL);

  logic        wr_ctrl, wr_depth, wr_stat;
  logic [31:0] ctrl_d;
  logic [2:0]  dsel_d;
  logic        frz_d;

  always_comb begin
    wr_ctrl  = csr_we && (csr_sel == SEL_CTRL);
    wr_depth = csr_we && (csr_sel == SEL_DEPTH);
    wr_stat  = csr_we && (csr_sel == SEL_STAT);
    ctrl_d   = csr_wdata & CTRL_MASK;
    dsel_d   = (csr_wdata[2:0] > SEL_LIMIT) ? SEL_LIMIT : csr_wdata[2:0];
    frz_d    = frozen_q;
    if (wr_stat) frz_d = csr_wdata[0];
    if (ovf_evt && ctrl_q[CB_FRZ]) frz_d = 1'b1;
    if (clr_cmd) frz_d = 1'b0;
    inval_all = clr_cmd || wr_depth;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      dsel_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q <= ctrl_d;
      if (wr_depth) dsel_q <= dsel_d;
      frozen_q <= frz_d;
    end
  end

  always_comb begin
    unique case (csr_sel)
      SEL_CTRL:  csr_rdata = ctrl_q;
      SEL_DEPTH: csr_rdata = {29'd0, dsel_q};
      SEL_STAT:  csr_rdata = {31'd0, frozen_q};
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/brh_filter.sv
`timescale 1ns/1ps
module brh_filter
  import brh_pkg::*;
(
  input  logic        rec_valid,
  input  logic [3:0]  rec_type,
  input  logic [1:0]  rec_priv,
  input  logic        en_user,
  input  logic        en_sup,
  input  logic        stk_mode,
  input  logic [15:0] inh_bits,
  input  logic        frozen,
  output logic        push,
  output logic        pop
);
  logic priv_ok, kind_ok, accept, is_call, is_ret;

  always_comb begin
    priv_ok = ((rec_priv == PRV_U) && en_user) || ((rec_priv == PRV_S) && en_sup);
    kind_ok = INH_IMPL[rec_type] && !inh_bits[rec_type];
    accept  = rec_valid && !frozen && priv_ok && kind_ok;
    is_call = (rec_type == K_ICALL) || (rec_type == K_DCALL);
    is_ret  = (rec_type == K_RET);
    pop     = accept && stk_mode && is_ret;
    push    = accept && (stk_mode ? is_call : 1'b1);
  end
endmodule

// File: rtl/brh_store.sv
`timescale 1ns/1ps
module brh_store #(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int MAX_SEL = 2,
  localparam int N      = 16 << MAX_SEL,
  localparam int PW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          inval_all,
  input  logic [2:0]    dsel,
  input  logic [AW-1:0] rec_src,
  input  logic [AW-1:0] rec_tgt,
  input  logic          rec_misp,
  input  logic [3:0]    rec_type,
  input  logic [CW-1:0] rec_cyc,
  input  logic [PW:0]   rd_idx,
  output logic [AW:0]   rd_src,
  output logic [AW:0]   rd_tgt,
  output logic [CW+3:0] rd_data
);
  logic [AW-1:0] src_m [N];
  logic [AW:0]   tgt_m [N];
  logic [CW+3:0] dat_m [N];

  logic [N-1:0]  vld_q, vld_d;
  logic [PW-1:0] head_q, head_d, wptr, mask, phys;
  logic [PW:0]   depth_n;
  logic          pop_ok, head_en, wr_en, hit;

  always_comb begin
    depth_n = (PW+1)'(16) << dsel;
    mask    = PW'(depth_n - 1'b1);
    wptr    = (head_q - 1'b1) & mask;
    pop_ok  = pop && vld_q[head_q];
    wr_en   = push && !inval_all;
    vld_d   = vld_q;
    head_d  = head_q;
    if (inval_all) begin
      vld_d  = '0;
      head_d = '0;
    end else if (push) begin
      vld_d[wptr] = 1'b1;
      head_d      = wptr;
    end else if (pop_ok) begin
      vld_d[head_q] = 1'b0;
      head_d        = (head_q + 1'b1) & mask;
    end
    head_en = inval_all || push || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
    end else if (head_en) begin
      vld_q  <= vld_d;
      head_q <= head_d;
    end
  end

  // record payload: one write port, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_m[wptr] <= rec_src;
      tgt_m[wptr] <= {rec_misp, rec_tgt};
      dat_m[wptr] <= {rec_cyc, rec_type};
    end
  end

  always_comb begin
    phys    = (head_q + rd_idx[PW-1:0]) & mask;
    hit     = (rd_idx < depth_n) && vld_q[phys];
    rd_src  = hit ? {1'b1, src_m[phys]} : '0;
    rd_tgt  = hit ? tgt_m[phys] : '0;
    rd_data = hit ? dat_m[phys] : '0;
  end
endmodule

// File: rtl/branch_hist_buf.sv
`timescale 1ns/1ps
module branch_hist_buf
  import brh_pkg::*;
#(
  parameter int  AW        = 32,
  parameter int  CW        = 16,
  parameter int  MAX_SEL   = 2,
  parameter bit  HAS_STACK = 1'b1,
  localparam int IW        = $clog2(16 << MAX_SEL) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  logic [3:0]    rec_type,
  input  logic [1:0]    rec_priv,
  input  logic [AW-1:0] rec_src,
  input  logic [AW-1:0] rec_tgt,
  input  logic          rec_misp,
  input  logic [CW-1:0] rec_cyc,
  input  logic          ovf_evt,
  input  logic          clr_cmd,
  input  logic          csr_we,
  input  logic [1:0]    csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic [IW-1:0] rd_idx,
  output logic [AW:0]   rd_src,
  output logic [AW:0]   rd_tgt,
  output logic [CW+3:0] rd_data
);
  logic [31:0] ctrl_q;
  logic [2:0]  dsel_q;
  logic        frozen_q, inval_all, push, pop;

  brh_regs #(.MAX_SEL(MAX_SEL), .HAS_STACK(HAS_STACK)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .clr_cmd(clr_cmd), .ovf_evt(ovf_evt),
    .ctrl_q(ctrl_q), .dsel_q(dsel_q), .frozen_q(frozen_q),
    .inval_all(inval_all), .csr_rdata(csr_rdata)
  );

  brh_filter u_filter (
    .rec_valid(rec_valid), .rec_type(rec_type), .rec_priv(rec_priv),
    .en_user(ctrl_q[CB_UEN]), .en_sup(ctrl_q[CB_SEN]),
    .stk_mode(ctrl_q[CB_STK]), .inh_bits(ctrl_q[31:16]),
    .frozen(frozen_q), .push(push), .pop(pop)
  );

  brh_store #(.AW(AW), .CW(CW), .MAX_SEL(MAX_SEL)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .inval_all(inval_all),
    .dsel(dsel_q), .rec_src(rec_src), .rec_tgt(rec_tgt), .rec_misp(rec_misp),
    .rec_type(rec_type), .rec_cyc(rec_cyc), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_data(rd_data)
  );
endmodule

// File: rtl/brh_chk.sv
`timescale 1ns/1ps
module brh_chk
  import brh_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int MAX_SEL   = 2,
  parameter bit HAS_STACK = 1'b1,
  parameter int IW        = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_cmd,
  input logic          ovf_evt,
  input logic          csr_we,
  input logic [1:0]    csr_sel,
  input logic [31:0]   csr_rdata,
  input logic [IW-1:0] rd_idx,
  input logic [AW:0]   rd_src,
  input logic [AW:0]   rd_tgt,
  input logic [CW+3:0] rd_data,
  input logic [3:0]    rec_type,
  input logic [1:0]    rec_priv,
  input logic [3:0]    ctl_lo,
  input logic [15:0]   ctl_inh,
  input logic [2:0]    dsel_q,
  input logic          frozen_q,
  input logic          push,
  input logic          pop
);
  localparam logic [31:0] CTRL_MASK = {INH_IMPL, 12'h000, HAS_STACK, 3'b111};

  logic out_rng;
  assign out_rng = 32'(rd_idx) >= (32'd16 << dsel_q);

  // R6
  freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctl_lo[CB_FRZ] && !clr_cmd) |=> frozen_q);
  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !clr_cmd && !(csr_we && csr_sel == SEL_STAT)) |=> frozen_q);
  // R6
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (!push && !pop));
  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (rd_src == '0 && !frozen_q));
  // R5
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsel_q <= 3'(MAX_SEL));
  // R5
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rng |-> (rd_src == '0 && rd_tgt == '0 && rd_data == '0));
  // R9
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SEL_CTRL) |-> ((csr_rdata & ~CTRL_MASK) == 32'd0));
  // R3
  priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((rec_priv == PRV_U && ctl_lo[CB_UEN]) || (rec_priv == PRV_S && ctl_lo[CB_SEN])));
  // R4
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !ctl_inh[rec_type]);
  // R8
  stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ctl_lo[CB_STK]) |-> (rec_type == K_ICALL || rec_type == K_DCALL));
endmodule

bind branch_hist_buf brh_chk #(
  .AW(AW), .CW(CW), .MAX_SEL(MAX_SEL), .HAS_STACK(HAS_STACK), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .ovf_evt(ovf_evt),
  .csr_we(csr_we), .csr_sel(csr_sel), .csr_rdata(csr_rdata),
  .rd_idx(rd_idx), .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_data(rd_data),
  .rec_type(rec_type), .rec_priv(rec_priv), .ctl_lo(ctrl_q[3:0]),
  .ctl_inh(ctrl_q[31:16]), .dsel_q(dsel_q), .frozen_q(frozen_q),
  .push(push), .pop(pop)
);

// File: tb/tb_branch_hist_buf.sv
`timescale 1ns/1ps
module tb_branch_hist_buf;
  localparam int AW = 32, CW = 16, MAX_SEL = 2;
  localparam int IW = $clog2(16 << MAX_SEL) + 1;

  typedef struct packed {
    logic [3:0] typ;
    logic [1:0] prv;
    logic       rec;
  } vec_t;

  // control for the table: user+supervisor on, kinds 5 and 10 inhibited
  localparam logic [31:0] TABLE_CTRL = 32'h0420_0003;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd9, 2'd0, 1'b1}, '{4'd5, 2'd0, 1'b0}, '{4'd10, 2'd1, 1'b0},
    '{4'd8, 2'd1, 1'b1}, '{4'd4, 2'd0, 1'b0}, '{4'd0, 2'd1, 1'b0},
    '{4'd6, 2'd0, 1'b0}, '{4'd1, 2'd0, 1'b1}, '{4'd2, 2'd1, 1'b1},
    '{4'd13, 2'd3, 1'b0}, '{4'd13, 2'd1, 1'b1}, '{4'd15, 2'd2, 1'b0},
    '{4'd3, 2'd0, 1'b1}, '{4'd12, 2'd1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rec_valid = 1'b0, rec_misp = 1'b0, ovf_evt = 1'b0, clr_cmd = 1'b0, csr_we = 1'b0;
  logic [3:0]    rec_type = '0;
  logic [1:0]    rec_priv = '0, csr_sel = '0;
  logic [AW-1:0] rec_src = '0, rec_tgt = '0;
  logic [CW-1:0] rec_cyc = '0;
  logic [31:0]   csr_wdata = '0, csr_rdata;
  logic [IW-1:0] rd_idx = '0;
  logic [AW:0]   rd_src, rd_tgt;
  logic [CW+3:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  branch_hist_buf #(.AW(AW), .CW(CW), .MAX_SEL(MAX_SEL)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_type(rec_type),
    .rec_priv(rec_priv), .rec_src(rec_src), .rec_tgt(rec_tgt), .rec_misp(rec_misp),
    .rec_cyc(rec_cyc), .ovf_evt(ovf_evt), .clr_cmd(clr_cmd), .csr_we(csr_we),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_idx(rd_idx), .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] t, input logic [1:0] p, input logic [AW-1:0] s,
                      input logic [AW-1:0] g, input logic m, input logic [CW-1:0] c,
                      input logic ovf = 1'b0);
    rec_valid = 1'b1; rec_type = t; rec_priv = p; rec_src = s; rec_tgt = g;
    rec_misp = m; rec_cyc = c; ovf_evt = ovf;
    @(negedge clk);
    rec_valid = 1'b0; ovf_evt = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    csr_sel = sel; #1; d = csr_rdata;
  endtask

  task automatic do_clear();
    clr_cmd = 1'b1;
    @(negedge clk);
    clr_cmd = 1'b0;
  endtask

  task automatic chk_rec(input string tag, input int idx, input logic [AW-1:0] s,
                         input logic [AW-1:0] g, input logic m, input logic [CW-1:0] c,
                         input logic [3:0] t);
    rd_idx = IW'(idx); #1;
    chk({tag, " src"}, 64'(rd_src), 64'({1'b1, s}));
    chk({tag, " tgt"}, 64'(rd_tgt), 64'({m, g}));
    chk({tag, " data"}, 64'(rd_data), 64'({c, t}));
  endtask

  task automatic chk_src(input string tag, input int idx, input logic [AW-1:0] s);
    rd_idx = IW'(idx); #1;
    chk(tag, 64'(rd_src), 64'({1'b1, s}));
  endtask

  task automatic chk_empty(input string tag, input int idx);
    rd_idx = IW'(idx); #1;
    chk({tag, " src"}, 64'(rd_src), 64'd0);
    chk({tag, " tgt"}, 64'(rd_tgt), 64'd0);
    chk({tag, " data"}, 64'(rd_data), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [AW-1:0] last_s, last_g;
    logic last_m;
    logic [CW-1:0] last_c;
    logic [3:0] last_t;
    int cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset values through every select
    rd_reg(2'd0, r); chk("R1 ctrl reset", 64'(r), 64'd0);
    rd_reg(2'd1, r); chk("R1 depth reset", 64'(r), 64'd0);
    rd_reg(2'd2, r); chk("R1 status reset", 64'(r), 64'd0);
    rd_reg(2'd3, r); chk("R11 unused select", 64'(r), 64'd0);
    chk_empty("R1 R10 idx0 after reset", 0);

    // R9: probe implemented control bits
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, r); chk("R9 ctrl probe", 64'(r), 64'hFF2E_000F);
    // R5: depth clamps to the built maximum
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, r); chk("R5 depth clamp", 64'(r), 64'(MAX_SEL));
    wr_reg(2'd1, 32'd0);

    // R2 / R3 / R4: table of transfers under a fixed filter
    wr_reg(2'd0, TABLE_CTRL);
    cnt = 0; last_s = '0; last_g = '0; last_m = 1'b0; last_c = '0; last_t = '0;
    for (int k = 0; k < NV; k++) begin
      xfer(VECS[k].typ, VECS[k].prv, AW'(32'h1000 + k), AW'(32'h2000 + k),
           k[0], CW'(k * 3));
      if (VECS[k].rec) begin
        cnt++;
        last_s = AW'(32'h1000 + k); last_g = AW'(32'h2000 + k); last_m = k[0];
        last_c = CW'(k * 3); last_t = VECS[k].typ;
      end
      if (cnt == 0) chk_empty($sformatf("R3 R4 vec %0d not kept", k), 0);
      else chk_rec($sformatf("R2 R3 R4 vec %0d", k), 0, last_s, last_g, last_m, last_c, last_t);
    end
    chk_src("R2 oldest at idx6", 6, AW'(32'h1000));
    chk_empty("R10 idx7 never written", 7);

    // R3: control 0 stops recording
    wr_reg(2'd0, 32'd0);
    xfer(4'd9, 2'd0, 32'h5555, 32'h6666, 1'b0, 16'd1);
    chk_src("R3 ctrl zero blocks", 0, AW'(32'h100D));

    // R5: wrap at 16, range limit, invalidation by depth write
    wr_reg(2'd0, 32'h3);
    do_clear();
    for (int j = 0; j < 17; j++) xfer(4'd11, 2'd0, AW'(32'h3000 + j), 32'h0, 1'b0, 16'd0);
    chk_src("R5 wrap newest", 0, AW'(32'h3010));
    chk_src("R5 wrap oldest", 15, AW'(32'h3001));
    chk_empty("R5 idx16 out of range", 16);
    wr_reg(2'd1, 32'd1);
    chk_empty("R5 depth write empties", 0);
    for (int j = 0; j < 20; j++) xfer(4'd11, 2'd1, AW'(32'h4000 + j), 32'h0, 1'b0, 16'd0);
    chk_src("R5 depth32 oldest", 19, AW'(32'h4000));
    chk_empty("R5 depth32 idx20 empty", 20);
    chk_empty("R5 depth32 idx32 out of range", 32);

    // R6: freeze on overflow
    wr_reg(2'd0, 32'h3);
    xfer(4'd1, 2'd0, 32'h7000, 32'h0, 1'b0, 16'd0, 1'b1);
    rd_reg(2'd2, r); chk("R6 no freeze when disabled", 64'(r), 64'd0);
    wr_reg(2'd0, 32'h7);
    do_clear();
    xfer(4'd1, 2'd0, 32'h7100, 32'h0, 1'b0, 16'd0);
    xfer(4'd2, 2'd0, 32'h7200, 32'h0, 1'b0, 16'd0, 1'b1);
    rd_reg(2'd2, r); chk("R6 frozen set", 64'(r), 64'd1);
    chk_src("R6 same-cycle transfer kept", 0, AW'(32'h7200));
    xfer(4'd3, 2'd0, 32'h7300, 32'h0, 1'b0, 16'd0);
    chk_src("R6 frozen blocks", 0, AW'(32'h7200));
    wr_reg(2'd2, 32'd0);
    rd_reg(2'd2, r); chk("R6 status cleared", 64'(r), 64'd0);
    xfer(4'd3, 2'd0, 32'h7400, 32'h0, 1'b0, 16'd0);
    chk_src("R6 recording resumes", 0, AW'(32'h7400));

    // R7: clear empties history and zeroes status, keeps control/depth
    xfer(4'd1, 2'd0, 32'h7500, 32'h0, 1'b0, 16'd0, 1'b1);
    do_clear();
    rd_reg(2'd2, r); chk("R7 status zero", 64'(r), 64'd0);
    rd_reg(2'd0, r); chk("R7 ctrl kept", 64'(r), 64'h7);
    rd_reg(2'd1, r); chk("R7 depth kept", 64'(r), 64'd1);
    chk_empty("R7 idx0 empty", 0);
    chk_empty("R7 idx1 empty", 1);

    // R8: stack emulation
    wr_reg(2'd0, 32'hB);
    do_clear();
    xfer(4'd9, 2'd0, 32'h8001, 32'h9001, 1'b1, 16'd4);
    xfer(4'd8, 2'd0, 32'h8002, 32'h9002, 1'b0, 16'd5);
    xfer(4'd11, 2'd0, 32'h8003, 32'h9003, 1'b0, 16'd6);
    chk_src("R8 jump not kept", 0, AW'(32'h8002));
    xfer(4'd13, 2'd0, 32'h8004, 32'h9004, 1'b0, 16'd7);
    chk_rec("R8 return pops", 0, 32'h8001, 32'h9001, 1'b1, 16'd4, 4'd9);
    chk_empty("R8 popped slot", 1);
    xfer(4'd13, 2'd0, 32'h8005, 32'h9005, 1'b0, 16'd0);
    chk_empty("R8 second pop empties", 0);
    xfer(4'd13, 2'd0, 32'h8006, 32'h9006, 1'b0, 16'd0);
    chk_empty("R8 pop on empty", 0);
    xfer(4'd9, 2'd1, 32'h8007, 32'h9007, 1'b0, 16'd0);
    chk_src("R8 push after empty pop", 0, AW'(32'h8007));
    chk_empty("R8 nothing below", 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule